// File: doc/BRIEF.md
# Timer slave mode controller

This block is a counter whose clocking is decided by a slave-mode controller. One trigger source is picked from eight candidates: four internal trigger lines, an edge-detected copy of timer input 1, the two conditioned timer inputs, and an external trigger. The selected trigger, or the pair of timer inputs, then drives the counter in one of eight ways. It can free-run on the system clock. It can count as a quadrature decoder in three variants. It can be cleared by the trigger, gated by the trigger level, started by a trigger edge, or stepped by trigger edges.

The counter wraps inside the range 0 to the reload value. Each wrap, and each clear in reset mode, produces a one-cycle update pulse. A one-cycle trigger event pulse reports every rising edge of the selected trigger, whatever the mode. All inputs are plain control levels sampled on the rising clock edge. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. Every output is registered.

Top module: `tsm_top`

## Requirements
- R1: While rst_n is low and in the first cycle after it, count is 0, dir_down is 0, update is 0 and trig_evt is 0.
- R2: trig_sel picks the trigger as follows: 0 to 3 pick int_trig[0] to int_trig[3], 4 picks ti1_edge, 5 picks ti1_fp, 6 picks ti2_fp and 7 picks ext_trig. A rising edge on any input that is not selected has no effect.
- R3: A low-to-high change of the selected trigger, seen between two consecutive clock samples, makes trig_evt high for exactly the following cycle, in every slave mode.
- R4: With slave_mode 0 the count advances by one on each clock while cnt_en is high, and holds while cnt_en is low.
- R5: Outside the encoder modes the counter only counts up. An upward step taken with count equal to or above arr loads 0 and raises update for one cycle.
- R6: slave_mode 1 steps only on edges of ti2_fp, while cnt_en is high. After the edge the step is up when ti2_fp equals ti1_fp and down otherwise. Edges of ti1_fp are ignored.
- R7: slave_mode 2 steps only on edges of ti1_fp, while cnt_en is high. After the edge the step is up when ti1_fp differs from ti2_fp and down otherwise. Edges of ti2_fp are ignored.
- R8: slave_mode 3 steps on edges of either input, with the direction rules of R6 and R7. If both inputs change in the same cycle, no step is taken.
- R9: In the encoder modes a downward step from 0 loads arr and raises update. dir_down holds the direction of the last encoder step. In modes 0 and 4 to 7 dir_down is 0.
- R10: With slave_mode 4 a rising trigger edge loads 0 into the count and raises update, taking priority over counting. Otherwise the count advances on each clock while cnt_en is high.
- R11: With slave_mode 5 the count advances on each clock only while cnt_en and the selected trigger level are both high.
- R12: With slave_mode 6 a rising trigger edge sets an internal run enable that only reset clears. The count advances on each clock after that edge, and also whenever cnt_en is high.
- R13: With slave_mode 7 the count advances by one for each rising trigger edge while cnt_en is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ti1_fp | input | 1 | Conditioned timer input 1 |
| ti2_fp | input | 1 | Conditioned timer input 2 |
| ti1_edge | input | 1 | Edge-detected timer input 1 |
| int_trig | input | 4 | Internal trigger lines |
| ext_trig | input | 1 | External trigger |
| trig_sel | input | 3 | Trigger source code (R2) |
| slave_mode | input | 3 | Slave behaviour code (R4, R6 to R13) |
| arr | input | CNT_W | Reload value, the top of the count range |
| cnt_en | input | 1 | Counter enable |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | 1 when the last encoder step was downward |
| update | output | 1 | One-cycle pulse on wrap or trigger clear |
| trig_evt | output | 1 | One-cycle pulse per rising selected trigger |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. Edge detection compares each input with its value registered at the previous edge. The count, update, dir_down and trig_evt registers all load at that same edge. The bench changes inputs on the falling edge and moves its cycle model forward once from those inputs. It then waits for the next rising edge and compares all four outputs at the falling edge that follows, which is one full cycle after the stimulus.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int TSM_N_ITR = 4;

  typedef enum logic [2:0] {
    SM_OFF     = 3'd0,
    SM_ENC_B   = 3'd1,
    SM_ENC_A   = 3'd2,
    SM_ENC_AB  = 3'd3,
    SM_RESET   = 3'd4,
    SM_GATED   = 3'd5,
    SM_TRIGGER = 3'd6,
    SM_EXTCLK  = 3'd7
  } slave_mode_e;

  typedef enum logic [2:0] {
    TS_ITR0  = 3'd0,
    TS_ITR1  = 3'd1,
    TS_ITR2  = 3'd2,
    TS_ITR3  = 3'd3,
    TS_EDGE1 = 3'd4,
    TS_IN1   = 3'd5,
    TS_IN2   = 3'd6,
    TS_EXT   = 3'd7
  } trig_src_e;
endpackage

// File: rtl/tsm_trig_sel.sv
module tsm_trig_sel
  import tsm_pkg::*;
#(
  parameter int N_ITR = TSM_N_ITR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ITR-1:0] int_trig,
  input  logic             ti1_edge,
  input  logic             ti1_fp,
  input  logic             ti2_fp,
  input  logic             ext_trig,
  input  logic [2:0]       sel,
  output logic             trig_lvl,
  output logic             trig_rise
);
  localparam int IDX_W = (N_ITR > 1) ? $clog2(N_ITR) : 1;

  logic trig_q;

  always_comb begin
    unique case (trig_src_e'(sel))
      TS_EDGE1: trig_lvl = ti1_edge;
      TS_IN1:   trig_lvl = ti1_fp;
      TS_IN2:   trig_lvl = ti2_fp;
      TS_EXT:   trig_lvl = ext_trig;
      default:  trig_lvl = int_trig[sel[IDX_W-1:0]];
    endcase
  end

  // previous sample of the chosen line, for rising-edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_lvl;
  end

  assign trig_rise = trig_lvl & ~trig_q;
endmodule

// File: rtl/tsm_quad.sv
module tsm_quad
  import tsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ti1,
  input  logic        ti2,
  input  slave_mode_e mode,
  output logic        enc_step,
  output logic        enc_down
);
  logic ti1_q, ti2_q, e1, e2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ti1_q <= 1'b0;
      ti2_q <= 1'b0;
    end else begin
      ti1_q <= ti1;
      ti2_q <= ti2;
    end
  end

  assign e1 = ti1 ^ ti1_q;
  assign e2 = ti2 ^ ti2_q;

  // forward rotation: input 1 leads input 2 -> count up
  always_comb begin
    enc_step = 1'b0;
    enc_down = 1'b0;
    unique case (mode)
      SM_ENC_B: begin
        enc_step = e2;
        enc_down = (ti2 != ti1);
      end
      SM_ENC_A: begin
        enc_step = e1;
        enc_down = (ti1 == ti2);
      end
      SM_ENC_AB: begin
        enc_step = e1 ^ e2;
        enc_down = e1 ? (ti1 == ti2) : (ti2 != ti1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsm_count.sv
module tsm_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             clear,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] count,
  output logic             update
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      update <= 1'b0;
    end else begin
      update <= 1'b0;
      if (clear) begin
        count  <= '0;
        update <= 1'b1;
      end else if (tick) begin
        if (down) begin
          if (count == '0) begin
            count  <= arr;
            update <= 1'b1;
          end else begin
            count <= count - ONE;
          end
        end else if (count >= arr) begin
          count  <= '0;
          update <= 1'b1;
        end else begin
          count <= count + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/tsm_top.sv
module tsm_top
  import tsm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ti1_fp,
  input  logic                 ti2_fp,
  input  logic                 ti1_edge,
  input  logic [TSM_N_ITR-1:0] int_trig,
  input  logic                 ext_trig,
  input  logic [2:0]           trig_sel,
  input  logic [2:0]           slave_mode,
  input  logic [CNT_W-1:0]     arr,
  input  logic                 cnt_en,
  output logic [CNT_W-1:0]     count,
  output logic                 dir_down,
  output logic                 update,
  output logic                 trig_evt
);
  slave_mode_e mode;
  logic trig_lvl, trig_rise, enc_step, enc_down;
  logic run_q, is_enc, tick, down, clr;

  assign mode = slave_mode_e'(slave_mode);

  tsm_trig_sel #(.N_ITR(TSM_N_ITR)) u_sel (
    .clk(clk), .rst_n(rst_n), .int_trig(int_trig), .ti1_edge(ti1_edge),
    .ti1_fp(ti1_fp), .ti2_fp(ti2_fp), .ext_trig(ext_trig), .sel(trig_sel),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise)
  );

  tsm_quad u_quad (
    .clk(clk), .rst_n(rst_n), .ti1(ti1_fp), .ti2(ti2_fp), .mode(mode),
    .enc_step(enc_step), .enc_down(enc_down)
  );

  always_comb begin
    is_enc = (mode == SM_ENC_B) || (mode == SM_ENC_A) || (mode == SM_ENC_AB);
    tick   = 1'b0;
    down   = 1'b0;
    clr    = 1'b0;
    unique case (mode)
      SM_OFF:     tick = cnt_en;
      SM_RESET: begin
        clr  = trig_rise;
        tick = cnt_en;
      end
      SM_GATED:   tick = cnt_en & trig_lvl;
      SM_TRIGGER: tick = cnt_en | run_q;
      SM_EXTCLK:  tick = cnt_en & trig_rise;
      default: begin
        tick = cnt_en & enc_step;
        down = enc_down;
      end
    endcase
  end

  tsm_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .down(down), .clear(clr),
    .arr(arr), .count(count), .update(update)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      dir_down <= 1'b0;
      trig_evt <= 1'b0;
    end else begin
      trig_evt <= trig_rise;
      if (mode == SM_TRIGGER && trig_rise) run_q <= 1'b1;
      if (!is_enc)   dir_down <= 1'b0;
      else if (tick) dir_down <= down;
    end
  end
endmodule

// File: rtl/tsm_checks.sv
module tsm_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       slave_mode,
  input logic             cnt_en,
  input logic [CNT_W-1:0] arr,
  input logic [CNT_W-1:0] count,
  input logic             update,
  input logic             dir_down,
  input logic             trig_evt,
  input logic             trig_rise
);
  a_r3_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> !trig_evt);

  a_r3_evt_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> trig_evt);

  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd0 && !cnt_en) |=> $stable(count));

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd0 && cnt_en && count >= arr) |=> (count == '0 && update));

  a_r9_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd0 || slave_mode >= 3'd4) |=> !dir_down);

  a_r10_trigger_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd4 && trig_rise) |=> (count == '0 && update));

  a_r13_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd7 && !trig_rise) |=> $stable(count));
endmodule

bind tsm_top tsm_checks #(.CNT_W(CNT_W)) u_tsm_checks (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .cnt_en(cnt_en),
  .arr(arr), .count(count), .update(update), .dir_down(dir_down),
  .trig_evt(trig_evt), .trig_rise(trig_rise)
);

// File: tb/tsm_top_bench.sv
module tsm_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ti1_fp = 0, ti2_fp = 0, ti1_edge = 0, ext_trig = 0, cnt_en = 0;
  logic [3:0] int_trig = '0;
  logic [2:0] trig_sel = '0, slave_mode = '0;
  logic [W-1:0] arr = '0;
  logic [W-1:0] count;
  logic dir_down, update, trig_evt;

  int n_vec = 0;
  int n_err = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_cnt;
  logic m_dir, m_upd, m_evt, m_trq, m_t1q, m_t2q, m_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsm_top #(.CNT_W(W)) u_tsm_top (
    .clk(clk), .rst_n(rst_n), .ti1_fp(ti1_fp), .ti2_fp(ti2_fp),
    .ti1_edge(ti1_edge), .int_trig(int_trig), .ext_trig(ext_trig),
    .trig_sel(trig_sel), .slave_mode(slave_mode), .arr(arr), .cnt_en(cnt_en),
    .count(count), .dir_down(dir_down), .update(update), .trig_evt(trig_evt)
  );

  function automatic logic sel_trig();
    case (trig_sel)
      3'd4: return ti1_edge;
      3'd5: return ti1_fp;
      3'd6: return ti2_fp;
      3'd7: return ext_trig;
      default: return int_trig[trig_sel[1:0]];
    endcase
  endfunction

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R10";
      3'd5: return "R11";
      3'd6: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_dir = 0; m_upd = 0; m_evt = 0;
    m_trq = 0; m_t1q = 0; m_t2q = 0; m_run = 0;
  endtask

  // advance the model by one clock from the currently driven inputs
  task automatic model_step();
    logic trig, rise, e1, e2, stp, dn, enc;
    trig = sel_trig();
    rise = trig & ~m_trq;
    e1 = ti1_fp ^ m_t1q;
    e2 = ti2_fp ^ m_t2q;
    stp = 0; dn = 0;
    enc = (slave_mode >= 3'd1 && slave_mode <= 3'd3);
    case (slave_mode)
      3'd0, 3'd4: stp = cnt_en;
      3'd1: begin stp = cnt_en & e2; dn = (ti2_fp != ti1_fp); end
      3'd2: begin stp = cnt_en & e1; dn = (ti1_fp == ti2_fp); end
      3'd3: begin
        stp = cnt_en & (e1 ^ e2);
        dn = e1 ? (ti1_fp == ti2_fp) : (ti2_fp != ti1_fp);
      end
      3'd5: stp = cnt_en & trig;
      3'd6: stp = cnt_en | m_run;
      default: stp = cnt_en & rise;
    endcase
    m_upd = 0;
    if (slave_mode == 3'd4 && rise) begin
      m_cnt = '0; m_upd = 1;
    end else if (stp) begin
      if (dn) begin
        if (m_cnt == '0) begin m_cnt = arr; m_upd = 1; end
        else m_cnt = m_cnt - 1'b1;
      end else begin
        if (m_cnt >= arr) begin m_cnt = '0; m_upd = 1; end
        else m_cnt = m_cnt + 1'b1;
      end
    end
    if (!enc) m_dir = 0;
    else if (stp) m_dir = dn;
    if (slave_mode == 3'd6 && rise) m_run = 1;
    m_evt = rise;
    m_trq = trig; m_t1q = ti1_fp; m_t2q = ti2_fp;
  endtask

  task automatic compare(string tag);
    n_vec++;
    if (count !== m_cnt || dir_down !== m_dir || update !== m_upd || trig_evt !== m_evt) begin
      n_err++;
      $display("FAIL %s: count=%0d dir=%0b upd=%0b evt=%0b expected count=%0d dir=%0b upd=%0b evt=%0b",
               tag, count, dir_down, update, trig_evt, m_cnt, m_dir, m_upd, m_evt);
    end
  endtask

  // inputs are already driven (at a falling edge); result is due one cycle later
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    compare("R1");
    rst_n = 1'b1;
    step("R1");

    // R4 and R5: free-run with small reload, wrap to 0 with update
    arr = 16'd3; cnt_en = 1;
    for (int i = 0; i < 6; i++) step("R5");
    cnt_en = 0;
    for (int i = 0; i < 2; i++) step("R4");

    // R2: select internal line 2, pulse unselected line 1 then line 2
    trig_sel = 3'd2;
    int_trig[1] = 1; step("R2");
    int_trig[1] = 0; step("R2");
    int_trig[2] = 1; step("R2");
    int_trig[2] = 0; step("R3");
    trig_sel = 3'd7; ext_trig = 1; step("R2");
    ext_trig = 0; step("R2");

    // R9: encoder counting down through 0 wraps to arr
    slave_mode = 3'd3; cnt_en = 1; arr = 16'd5;
    ti2_fp = 1; step("R9");
    ti1_fp = 1; step("R9");
    ti2_fp = 0; step("R9");
    ti1_fp = 0; step("R9");
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) ti1_fp = ~ti1_fp; else ti2_fp = ~ti2_fp;
      step("R9");
    end
    ti1_fp = ~ti1_fp; ti2_fp = ~ti2_fp; step("R8");

    // R12: trigger start with enable low
    slave_mode = 3'd6; cnt_en = 0; trig_sel = 3'd0; arr = 16'd100;
    step("R12");
    int_trig[0] = 1; step("R12");
    int_trig[0] = 0;
    for (int i = 0; i < 4; i++) step("R12");

    // constrained random segments over every mode and trigger source
    for (int seg = 0; seg < 48; seg++) begin
      slave_mode = (seg < 16) ? seg[2:0] : 3'($urandom_range(0, 7));
      trig_sel   = 3'($urandom_range(0, 7));
      arr        = W'($urandom_range(0, 12));
      for (int c = 0; c < 120; c++) begin
        cnt_en   = ($urandom_range(0, 9) != 0);
        if ($urandom_range(0, 3) == 0) ti1_fp = ~ti1_fp;
        if ($urandom_range(0, 3) == 0) ti2_fp = ~ti2_fp;
        ti1_edge = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 3) == 0) ext_trig = ~ext_trig;
        for (int k = 0; k < 4; k++)
          if ($urandom_range(0, 3) == 0) int_trig[k] = ~int_trig[k];
        step(mode_tag(slave_mode));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule